// File: doc/BRIEF.md
# Externally Clocked Result Shifter with Sync Marker and Tag Chaining

This block is the serial output stage of a sampling converter whose data clock comes from outside. A conversion is started when chip select and read/convert are both low; the second of the two to fall starts it. The busy line then drops for a fixed number of system clocks. When busy rises, the code captured at the start of the conversion becomes the held result. A read state is entered when read/convert is high and chip select is low. On entry the held result is loaded into a shifter, and rising edges of the external clock move it out most significant bit first.

If the external clock toggled while no read was in progress, the first read edge raises a one-clock-period sync marker before any data bit. After the word, the block emits the tag level seen at read entry as a separator bit. It then repeats the tag input, one bit per edge. Several units can share one serial line this way, each tag input fed by the next unit's data output. All pins are brought into the system clock domain through a synchronizer, and clock edges are found there.

Top module: `xclk_result_shifter`

## Requirements
- R1: After reset, data_out is 0, sync_out is 0 and busy_out is 1.
- R2: A conversion starts when cs_n and rd_conv are both low and one of them has just gone low while busy_out is high. busy_out then falls within 4 system clocks and rises again after CONV_CYCLES clocks. The held result becomes the adc_code value present when the conversion started.
- R3: A read state starts on a rise of rd_conv while cs_n is low, or on a fall of cs_n while rd_conv is high. It loads the held result at entry, so a read begun during a conversion delivers the previously completed result.
- R4: With no sync marker due, the first rising edge of sclk_in in the read state drives bit 15 onto data_out. Each later edge drives the next lower bit, one bit per edge.
- R5: A sync marker is due when at least one rising sclk_in edge occurred outside the read state since the previous read entry. The first read edge then sets sync_out to 1 and leaves data_out unchanged. The next edge clears sync_out and drives bit 15.
- R6: The data edge after bit 0 drives the level tag_in had at read entry (the separator bit).
- R7: From the following edge on, data_out repeats tag_in. The value sampled at data edge k appears at data edge k+17.
- R8: Outside the read state, sclk_in edges leave data_out unchanged and sync_out stays 0.
- R9: Leaving the read state (cs_n high or rd_conv low) stops shifting. The next read restarts from bit 15 of the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External serial data clock (asynchronous) |
| tag_in | input | 1 | Serial chain input, sampled on sclk_in rising edges |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | High: read; low: convert |
| adc_code | input | DATA_W | Code captured at conversion start |
| data_out | output | 1 | Serial data output |
| sync_out | output | 1 | Sync marker before the word |
| busy_out | output | 1 | Low while a conversion runs |

## Verification
The hardest case to reach is the sync marker, because it depends on clock activity before the read began rather than on anything present at entry. The stimulus pulses sclk_in a varying number of times, zero included, between reads, and during an aborted read. A reference flag tracks whether a marker is due. The other hard case is a read entered while a conversion is still running and still in progress when busy rises. The bench keeps the read going across that point and expects the older word throughout.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef struct packed {
    logic sclk;
    logic tag;
    logic cs_n;
    logic rc;
  } xs_pins_t;

  localparam int PIN_W = $bits(xs_pins_t);
  localparam xs_pins_t PINS_IDLE = '{sclk: 1'b0, tag: 1'b0, cs_n: 1'b1, rc: 1'b1};
endpackage

// File: rtl/xs_sync.sv
module xs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else if (i == 0) st[i] <= d;
        else st[i] <= st[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/xs_conv_ctrl.sv
module xs_conv_ctrl #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              rc_s,
  input  logic [DATA_W-1:0] code_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic              cmd_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hold;
  logic              cmd, conv_start;

  assign cmd        = ~cs_n_s & ~rc_s;
  assign conv_start = cmd & ~cmd_q & busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= 1'b0;
      busy_o   <= 1'b1;
      cnt      <= '0;
      hold     <= '0;
      result_o <= '0;
    end else begin
      cmd_q <= cmd;
      if (conv_start) begin
        busy_o <= 1'b0;
        cnt    <= CNT_W'(CONV_CYCLES - 1);
        hold   <= code_i;
      end else if (!busy_o) begin
        if (cnt == '0) begin
          busy_o   <= 1'b1;
          result_o <= hold;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !busy_o);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(result_o));
endmodule

// File: rtl/xs_read_shifter.sv
module xs_read_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              tag_s,
  input  logic              cs_n_s,
  input  logic              rc_s,
  input  logic [DATA_W-1:0] result_i,
  output logic              data_o,
  output logic              sync_o
);
  logic            sclk_q, rd_q, idle_seen, sync_pend;
  logic [DATA_W:0] sh;
  logic            rd_act, rise, entry, rd_edge;

  assign rd_act  = ~cs_n_s & rc_s;
  assign rise    = sclk_s & ~sclk_q;
  assign entry   = rd_act & ~rd_q;
  assign rd_edge = rd_act & rd_q & rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      rd_q      <= 1'b0;
      idle_seen <= 1'b0;
      sync_pend <= 1'b0;
      sh        <= '0;
      data_o    <= 1'b0;
      sync_o    <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      rd_q   <= rd_act;
      if (entry) begin
        sh        <= {result_i, tag_s};
        sync_pend <= idle_seen;
        idle_seen <= 1'b0;
        sync_o    <= 1'b0;
      end else if (rd_edge) begin
        if (sync_pend) begin
          sync_o    <= 1'b1;
          sync_pend <= 1'b0;
        end else begin
          sync_o <= 1'b0;
          data_o <= sh[DATA_W];
          sh     <= {sh[DATA_W-1:0], tag_s};
        end
      end else begin
        if (!rd_act) sync_o <= 1'b0;
        if (!rd_act && rise) idle_seen <= 1'b1;
      end
    end
  end

  // R5
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_o && rd_edge) |=> !sync_o);
  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_edge |=> $stable(data_o));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> !sync_o);
  // R5
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_act && rise) |=> idle_seen);
endmodule

// File: rtl/xclk_result_shifter.sv
module xclk_result_shifter
  import xs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              tag_in,
  input  logic              cs_n,
  input  logic              rd_conv,
  input  logic [DATA_W-1:0] adc_code,
  output logic              data_out,
  output logic              sync_out,
  output logic              busy_out
);
  xs_pins_t          pins_raw, pins_s;
  logic [DATA_W-1:0] result;

  assign pins_raw = '{sclk: sclk_in, tag: tag_in, cs_n: cs_n, rc: rd_conv};

  xs_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  xs_conv_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rst(rst), .cs_n_s(pins_s.cs_n), .rc_s(pins_s.rc),
    .code_i(adc_code), .busy_o(busy_out), .result_o(result)
  );

  xs_read_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(pins_s.sclk), .tag_s(pins_s.tag),
    .cs_n_s(pins_s.cs_n), .rc_s(pins_s.rc), .result_i(result),
    .data_o(data_out), .sync_o(sync_out)
  );
endmodule

// File: tb/xclk_result_shifter_tb.sv
module xclk_result_shifter_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk_in = 1'b0, tag_in = 1'b0, cs_n = 1'b1, rd_conv = 1'b1;
  logic [15:0] adc_code = '0;
  logic data_out, sync_out, busy_out;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] cur_result = '0, rd_res = '0, pend_code = '0;
  bit idle_m = 0, sync_exp = 0, conv_pend = 0, last_data = 0, t0 = 0;
  bit tg [64];

  always #2.5 clk = ~clk;

  xclk_result_shifter u_dut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .tag_in(tag_in), .cs_n(cs_n),
    .rd_conv(rd_conv), .adc_code(adc_code), .data_out(data_out),
    .sync_out(sync_out), .busy_out(busy_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic pulse(input bit tv);
    tag_in = tv;
    tick(3);
    sclk_in = 1'b1;
    tick(6);
    sclk_in = 1'b0;
    tick(6);
  endtask

  function automatic bit exp_bit(input int m);
    if (m <= 16) return rd_res[16-m];
    if (m == 17) return t0;
    return tg[m-17];
  endfunction

  task automatic wait_busy();
    for (int i = 0; i < 1000 && !busy_out; i++) tick(1);
    chk("R2 busy returns high", 32'(busy_out), 32'd1);
  endtask

  task automatic do_conv(input logic [15:0] code);
    adc_code = code;
    rd_conv = 1'b0;
    tick(2);
    cs_n = 1'b0;
    tick(5);
    chk("R2 busy low after start", 32'(busy_out), 32'd0);
    wait_busy();
    cs_n = 1'b1;
    tick(2);
    rd_conv = 1'b1;
    tick(3);
    cur_result = code;
  endtask

  task automatic idle_pulses(input int k);
    for (int i = 0; i < k; i++) begin
      pulse(1'($urandom));
      chk("R8 data held outside read", 32'(data_out), 32'(last_data));
      chk("R8 sync low outside read", 32'(sync_out), 32'd0);
      idle_m = 1;
    end
  endtask

  task automatic enter_cs();
    t0 = 1'($urandom);
    tag_in = t0;
    tick(4);
    rd_res = cur_result;
    sync_exp = idle_m;
    idle_m = 0;
    cs_n = 1'b0;
    tick(5);
  endtask

  task automatic enter_conv(input logic [15:0] code);
    t0 = 1'($urandom);
    tag_in = t0;
    adc_code = code;
    rd_conv = 1'b0;
    tick(2);
    cs_n = 1'b0;
    tick(5);
    chk("R2 busy low at conversion read", 32'(busy_out), 32'd0);
    conv_pend = 1;
    pend_code = code;
    rd_res = cur_result;
    sync_exp = idle_m;
    idle_m = 0;
    rd_conv = 1'b1;
    tick(5);
  endtask

  task automatic run_read(input int n, input string lbl);
    int m = 0;
    for (int e = 1; e <= n; e++) begin
      bit tv = 1'($urandom);
      pulse(tv);
      if (sync_exp && e == 1) begin
        chk("R5 sync marker", 32'(sync_out), 32'd1);
        chk("R5 data held on marker", 32'(data_out), 32'(last_data));
      end else begin
        bit ex;
        string r;
        m++;
        tg[m] = tv;
        ex = exp_bit(m);
        r = (lbl != "") ? lbl : (m <= 16) ? "R4 data bit" : (m == 17) ? "R6 separator" : "R7 tag repeat";
        chk(sync_exp ? "R5 sync cleared" : "R4 no marker", 32'(sync_out), 32'd0);
        chk(r, 32'(data_out), 32'(ex));
        last_data = ex;
      end
    end
  endtask

  task automatic leave();
    cs_n = 1'b1;
    tick(5);
    chk("R9 sync low after exit", 32'(sync_out), 32'd0);
    if (conv_pend) begin
      wait_busy();
      cur_result = pend_code;
      conv_pend = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(5);
    rst = 1'b0;
    tick(4);
    // R1
    chk("R1 data reset", 32'(data_out), 32'd0);
    chk("R1 sync reset", 32'(sync_out), 32'd0);
    chk("R1 busy reset", 32'(busy_out), 32'd1);

    do_conv(16'hA5C3);
    enter_cs(); run_read(20, ""); leave();           // R4, R6, R7 without marker
    idle_pulses(2);
    enter_cs(); run_read(22, ""); leave();           // R5 with marker
    enter_cs(); run_read(5, ""); leave();            // R9 aborted read
    enter_cs(); run_read(17, "R9 restart from msb"); leave();
    enter_conv(16'h3C5A); run_read(18, "R3 previous result during conversion"); leave();
    enter_cs(); run_read(16, "R2 new result after busy"); leave();

    for (int it = 0; it < 10; it++) begin
      do_conv(16'($urandom));
      idle_pulses(int'($urandom % 3));
      if ($urandom % 2) begin
        enter_cs();
      end else begin
        enter_conv(16'($urandom));
      end
      run_read(16 + int'($urandom % 8), "");
      leave();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule